// File: doc/BRIEF.md
# Overcurrent Fault Latch and Clear Timer

This block supervises protection for a three-phase bridge of six gate outputs. It takes three digitised inputs: an overcurrent comparator flag, a pair of supply comparator flags that bracket the low-side supply, and an enable line. From these it produces a registered global shutdown, the six gated outputs and an active-low fault indication.

An overcurrent flag that survives a glitch filter trips a set-dominant latch. The latch holds while the trip is present. A clear timer then counts a run-time delay in clock cycles, starting only once the trip has ended, and the latch releases when the count is reached. A low supply also asserts the fault, but it releases as soon as the supply recovers, with no delay. The enable line passes through its own filter. It can force the outputs off, but it never raises the fault indication.

Top module: `oc_fault_supervisor`

## Requirements
- R1: While reset is high and just after it, `fault_n` is 0, `shutdown` is 1 and `gate_out` is all zeros. After reset the overcurrent latch is already set. The outputs stay off until the clear delay has run out, the supply state has been cleared by a pulse on `vcc_above_rise`, and the enable filter has settled high.
- R2: A high on `oc_flag` that lasts fewer than `OC_FILT` consecutive cycles has no effect on `fault_n` or `gate_out`.
- R3: When `oc_flag` is high for `OC_FILT` cycles, `fault_n` falls to 0 and `gate_out` becomes all zeros `OC_FILT`+1 clock edges after the first high sample.
- R4: While the filtered trip is present, the fault stays asserted however long the trip lasts.
- R5: With a clear delay D, after `oc_flag` falls `fault_n` stays 0 through edge `OC_FILT`+D+1. It returns to 1 at edge `OC_FILT`+D+2, and at that edge `gate_out` again equals `gate_cmd`.
- R6: A new qualified trip during the countdown restarts the clear timer from zero. The release again takes `OC_FILT`+D+2 edges, counted from the end of the new trip.
- R7: A clear delay of 0 releases the fault `OC_FILT`+2 edges after `oc_flag` falls.
- R8: A high sample on `vcc_below_fall` sets the undervoltage state. `fault_n` falls 2 edges later. A high sample on `vcc_above_rise` clears the state, and `fault_n` returns 2 edges later with no clear delay. If both flags are high, `vcc_below_fall` wins.
- R9: When both supply flags are low, the undervoltage state and `fault_n` hold their previous value (hysteresis).
- R10: When `enable_in` is low for `EN_FILT` cycles, `gate_out` goes to zero and `shutdown` goes to 1 at edge `EN_FILT`+1, while `fault_n` stays 1. A low pulse shorter than `EN_FILT` cycles is ignored.
- R11: With no fault and enable high, `gate_out` takes the value of `gate_cmd` one clock edge after it is applied. Bit i of `gate_cmd` drives bit i of `gate_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_flag | input | 1 | Digitised overcurrent comparator output, high = overcurrent |
| vcc_below_fall | input | 1 | Supply below the falling undervoltage threshold |
| vcc_above_rise | input | 1 | Supply above the rising undervoltage threshold |
| enable_in | input | 1 | Driver enable, high = outputs allowed |
| clear_delay | input | DLY_W | Fault clear delay in clock cycles |
| gate_cmd | input | 6 | Commanded gate states, one bit per switch |
| gate_out | output | 6 | Gated outputs, forced to zero during shutdown |
| shutdown | output | 1 | High when all outputs are being forced off |
| fault_n | output | 1 | Active-low fault indication (overcurrent or undervoltage) |

## Verification
The bench builds the block with `OC_FILT`=4, `EN_FILT`=6 and `DLY_W`=16. It drives `clear_delay` at run time with 10 and with 0. These short windows let every boundary be checked on its exact edge: the pulse one cycle shorter than the filter, the last edge before release, the release edge itself, and a re-trip in the middle of the countdown. The defaults (21 and 49 cycles) correspond to the nominal filter times at 100 MHz.

// File: rtl/oc_sup_pkg.sv
package oc_sup_pkg;
  localparam int GATE_N = 6;
  typedef logic [GATE_N-1:0] gate_vec_t;
endpackage

// File: rtl/oc_glitch_filter.sv
module oc_glitch_filter #(
  parameter int   FILT    = 21,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT < 2) ? 1 : $clog2(FILT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= RST_VAL;
      cnt  <= '0;
    end else if (din == dout) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      dout <= din;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(din) == dout)); // R2
endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip,
  input  logic [DLY_W-1:0] clear_dly,
  output logic             latched
);
  logic [DLY_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      latched <= 1'b1;
      timer   <= '0;
    end else if (trip) begin
      latched <= 1'b1;
      timer   <= '0;
    end else if (latched) begin
      if (timer >= clear_dly) latched <= 1'b0;
      else                    timer   <= timer + 1'b1;
    end
  end

  AST_TRIP_SETS_AND_ZEROES: assert property (@(posedge clk) disable iff (rst)
    trip |=> (latched && timer == '0)); // R6

  AST_HOLD_UNTIL_DELAY: assert property (@(posedge clk) disable iff (rst)
    (latched && timer < clear_dly && $stable(clear_dly)) |=> latched); // R5
endmodule

// File: rtl/oc_uv_state.sv
module oc_uv_state (
  input  logic clk,
  input  logic rst,
  input  logic below_fall,
  input  logic above_rise,
  output logic uv
);
  always_ff @(posedge clk) begin
    if (rst)             uv <= 1'b1;
    else if (below_fall) uv <= 1'b1;
    else if (above_rise) uv <= 1'b0;
  end

  AST_UV_HYST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!below_fall && !above_rise) |=> $stable(uv)); // R9
endmodule

// File: rtl/oc_fault_supervisor.sv
module oc_fault_supervisor
  import oc_sup_pkg::*;
#(
  parameter int OC_FILT = 21,
  parameter int EN_FILT = 49,
  parameter int DLY_W   = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oc_flag,
  input  logic             vcc_below_fall,
  input  logic             vcc_above_rise,
  input  logic             enable_in,
  input  logic [DLY_W-1:0] clear_delay,
  input  logic [5:0]       gate_cmd,
  output logic [5:0]       gate_out,
  output logic             shutdown,
  output logic             fault_n
);
  logic oc_q, en_q, oc_latched, uv_q;
  logic fault_any, kill_any;

  oc_glitch_filter #(.FILT(OC_FILT), .RST_VAL(1'b0)) u_oc_filt (
    .clk(clk), .rst(rst), .din(oc_flag), .dout(oc_q));

  oc_glitch_filter #(.FILT(EN_FILT), .RST_VAL(1'b0)) u_en_filt (
    .clk(clk), .rst(rst), .din(enable_in), .dout(en_q));

  oc_fault_latch #(.DLY_W(DLY_W)) u_latch (
    .clk(clk), .rst(rst), .trip(oc_q), .clear_dly(clear_delay),
    .latched(oc_latched));

  oc_uv_state u_uv (
    .clk(clk), .rst(rst), .below_fall(vcc_below_fall),
    .above_rise(vcc_above_rise), .uv(uv_q));

  assign fault_any = oc_q | oc_latched | uv_q;
  assign kill_any  = fault_any | ~en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_n  <= 1'b0;
      shutdown <= 1'b1;
    end else begin
      fault_n  <= ~fault_any;
      shutdown <= kill_any;
    end
  end

  for (genvar g = 0; g < GATE_N; g++) begin : g_leg
    always_ff @(posedge clk) begin
      if (rst) gate_out[g] <= 1'b0;
      else     gate_out[g] <= gate_cmd[g] & ~kill_any;
    end
  end

  AST_FAULT_IMPLIES_SHUT: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> shutdown); // R3

  AST_SHUT_GATES_ZERO: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> (gate_out == '0)); // R10

  AST_TRIP_ASSERTS_FAULT: assert property (@(posedge clk) disable iff (rst)
    oc_q |=> !fault_n); // R4
endmodule

// File: tb/oc_fault_supervisor_test.sv
module oc_fault_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int OCF = 4;
  localparam int ENF = 6;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst, oc_flag, below, above, en;
  logic [DW-1:0] dly;
  logic [5:0] cmd, gate_out;
  logic shutdown, fault_n;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_fault_supervisor #(.OC_FILT(OCF), .EN_FILT(ENF), .DLY_W(DW)) uut (
    .clk(clk), .rst(rst), .oc_flag(oc_flag), .vcc_below_fall(below),
    .vcc_above_rise(above), .enable_in(en), .clear_delay(dly),
    .gate_cmd(cmd), .gate_out(gate_out), .shutdown(shutdown),
    .fault_n(fault_n));

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1; oc_flag = 0; below = 0; above = 0; en = 1; dly = 10; cmd = 6'h2A;
    adv(3);
    chk("R1 fault_n in reset", fault_n, 0);
    chk("R1 shutdown in reset", shutdown, 1);
    chk("R1 gates in reset", gate_out, 0);
    rst = 0; above = 1;
    adv(1); above = 0;
    adv(7);
    chk("R1 fault held before delay", fault_n, 0);
    adv(12);
    chk("R1 fault released", fault_n, 1);
    chk("R1 gates follow after release", gate_out, 6'h2A);
  endtask

  task automatic t_cmd();
    cmd = 6'h15;
    chk("R11 gates before edge", gate_out, 6'h2A);
    adv(1);
    chk("R11 gates one edge later", gate_out, 6'h15);
  endtask

  task automatic t_short_oc();
    int bad = 0;
    oc_flag = 1; adv(OCF-1); oc_flag = 0;
    for (int i = 0; i < 12; i++) begin
      adv(1);
      if (fault_n != 1 || gate_out != cmd) bad++;
    end
    chk("R2 short trip ignored", bad, 0);
  endtask

  task automatic t_trip(input int d, input string rq);
    dly = DW'(d);
    oc_flag = 1;
    adv(OCF);
    chk("R3 no fault before filter", fault_n, 1);
    adv(1);
    chk("R3 fault asserted", fault_n, 0);
    chk("R3 gates off", gate_out, 0);
    adv(50);
    chk("R4 fault held during trip", fault_n, 0);
    oc_flag = 0;
    adv(OCF + d + 1);
    chk({rq, " fault held last edge"}, fault_n, 0);
    adv(1);
    chk({rq, " fault released"}, fault_n, 1);
    chk({rq, " gates restored"}, gate_out, cmd);
  endtask

  task automatic t_retrip();
    dly = 10;
    oc_flag = 1; adv(OCF + 3); oc_flag = 0;
    adv(OCF + 6);
    chk("R6 mid countdown fault", fault_n, 0);
    oc_flag = 1; adv(OCF + 1); oc_flag = 0;
    adv(OCF + 10 + 1);
    chk("R6 timer restarted, still held", fault_n, 0);
    adv(1);
    chk("R6 release after full delay", fault_n, 1);
  endtask

  task automatic t_uv();
    int bad = 0;
    below = 1; adv(1); below = 0;
    chk("R8 uv not yet visible", fault_n, 1);
    adv(1);
    chk("R8 uv fault asserted", fault_n, 0);
    chk("R8 uv gates off", gate_out, 0);
    adv(10);
    chk("R9 uv held without flags", fault_n, 0);
    below = 1; above = 1; adv(2); below = 0;
    chk("R8 below dominates", fault_n, 0);
    adv(1); above = 0;
    adv(1);
    chk("R8 uv released without delay", fault_n, 1);
    for (int i = 0; i < 10; i++) begin
      adv(1);
      if (fault_n != 1) bad++;
    end
    chk("R9 healthy held without flags", bad, 0);
  endtask

  task automatic t_enable();
    int bad = 0;
    en = 0; adv(ENF-1); en = 1;
    for (int i = 0; i < 12; i++) begin
      adv(1);
      if (gate_out != cmd) bad++;
    end
    chk("R10 short enable low ignored", bad, 0);
    en = 0;
    adv(ENF);
    chk("R10 gates on before filter", gate_out, cmd);
    adv(1);
    chk("R10 gates off", gate_out, 0);
    chk("R10 shutdown high", shutdown, 1);
    chk("R10 no fault from enable", fault_n, 1);
    en = 1;
    adv(ENF + 1);
    chk("R10 gates back", gate_out, cmd);
  endtask

  initial begin
    t_reset();
    t_cmd();
    t_short_oc();
    t_trip(10, "R5");
    t_trip(0, "R7");
    t_retrip();
    t_uv();
    t_enable();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule